// File: doc/BRIEF.md
# Dual-Pattern Inverse Coefficient Scan

This block takes the 64 quantized coefficients of one 8x8 block as a serial stream, indexed n = 0 to 63 in transmission order. It places each coefficient at the two-dimensional position (v, u) that the selected scan pattern assigns to index n. When all 64 have arrived, it delivers the block in raster order: row v outer, column u inner. A single flag, sampled with the first coefficient of each block, picks one of two patterns. The first is the classic zigzag. The second is a column-biased variant that is the zigzag mirrored about the main diagonal.

Two storage banks alternate between the roles of loading and draining. One block can therefore be written while the previous one is read out. Both the input side and the output side use valid/ready handshakes. The output marks the final word of each block. The input stalls only when both banks hold complete blocks that have not yet been drained.

Top module: `coef_iscan`

## Requirements
- R1: After reset, out_valid and out_last are 0 and in_ready is 1.
- R2: With in_alt = 0 on the first coefficient, coefficient n is stored at raster index v*8+u of the zigzag walk. The walk starts at (0,0), steps right along row 0 to (0,1), then goes down-left to (1,0), so n=1 lands at raster index 1 and n=2 at raster index 8. It then continues along anti-diagonals, alternating direction. Data values pass through bit-exact.
- R3: With in_alt = 1 on the first coefficient, coefficient n is stored at the transposed zigzag position. Zigzag position (v,u) becomes raster index u*8+v, so n=1 lands at raster index 8 and n=2 at raster index 1.
- R4: Each block leaves as exactly 64 words in raster index order 0..63. out_last is 1 on the 64th word and 0 on the others.
- R5: in_alt is sampled only when the first coefficient (n=0) of a block is accepted. Its value on coefficients 1..63 of that block has no effect on placement.
- R6: A new block is accepted while an earlier one is being read out. in_ready is 0 exactly when two complete blocks are waiting or being drained.
- R7: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last hold their values on the next cycle.
- R8: out_valid is 1 exactly when at least one complete block is held. Once a block's 64th word is taken, its bank is free and in_ready is 1 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input coefficient valid |
| in_ready | output | 1 | Block can accept a coefficient |
| in_data | input | W | Quantized coefficient, transmission order |
| in_alt | input | 1 | Pattern select, used with the first coefficient: 0 zigzag, 1 column-biased |
| out_valid | output | 1 | Output coefficient valid |
| out_ready | input | 1 | Consumer accepts the output word |
| out_data | output | W | Coefficient in raster order |
| out_last | output | 1 | Marks the 64th word of a block |

## Verification
The hardest state to reach from the ports is both banks full. In that state the input stalls while the output is held back, and at the same time a read completion frees a bank while a write completes into the other. The stimulus holds out_ready low for the first few hundred cycles, so that two blocks fill and the stall is observed and checked. After that it drives random valid and ready patterns from a fixed seed, so that block ends on both sides collide. The first blocks force the column pattern and then the zigzag pattern, and in_alt is randomized on every later coefficient to show that it is ignored there.

// File: rtl/isc_pkg.sv
package isc_pkg;

    typedef enum logic {
        SCAN_ZIGZAG = 1'b0,
        SCAN_COLUMN = 1'b1
    } scan_mode_e;

    // Raster index v*dim+u for transmission index n. Anti-diagonal d = v+u;
    // odd diagonals run with v rising, even diagonals with v falling.
    function automatic int scan_pos(int n, int dim, logic column);
        int base;
        int res;
        base = 0;
        res  = 0;
        for (int d = 0; d < 2 * dim - 1; d++) begin
            int len;
            int vmin;
            int vmax;
            int v;
            int u;
            len  = (d < dim) ? d + 1 : 2 * dim - 1 - d;
            vmin = (d < dim) ? 0 : d - dim + 1;
            vmax = (d < dim) ? d : dim - 1;
            if (n >= base && n < base + len) begin
                v   = (d % 2 == 1) ? vmin + (n - base) : vmax - (n - base);
                u   = d - v;
                res = column ? (u * dim + v) : (v * dim + u);
            end
            base = base + len;
        end
        return res;
    endfunction

endpackage

// File: rtl/isc_addr_map.sv
module isc_addr_map
    import isc_pkg::*;
#(
    parameter int DIM = 8,
    parameter int N   = DIM * DIM,
    parameter int AW  = $clog2(N)
) (
    input  logic [AW-1:0] idx,
    input  scan_mode_e    mode,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] zz_tab  [N];
    logic [AW-1:0] col_tab [N];

    for (genvar g = 0; g < N; g++) begin : g_tab
        assign zz_tab[g]  = AW'(scan_pos(g, DIM, 1'b0));
        assign col_tab[g] = AW'(scan_pos(g, DIM, 1'b1));
    end

    assign addr = (mode == SCAN_COLUMN) ? col_tab[idx] : zz_tab[idx];
endmodule

// File: rtl/isc_bank.sv
module isc_bank #(
    parameter int W     = 12,
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/isc_wr_ctrl.sv
module isc_wr_ctrl
    import isc_pkg::*;
#(
    parameter int N  = 64,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_alt,
    input  logic          bank_free,
    output logic          in_ready,
    output logic          wr_en,
    output logic [AW-1:0] wr_idx,
    output scan_mode_e    wr_mode,
    output logic          wr_bank,
    output logic          blk_done
);
    localparam logic [AW-1:0] LAST_IDX = AW'(N - 1);

    typedef struct packed {
        logic [AW-1:0] idx;
        logic          bank;
        scan_mode_e    mode;
    } wr_state_t;

    wr_state_t st;
    logic      first;

    assign in_ready = bank_free;
    assign wr_en    = in_valid && bank_free;
    assign first    = (st.idx == '0);
    assign wr_mode  = first ? scan_mode_e'(in_alt) : st.mode;
    assign wr_idx   = st.idx;
    assign wr_bank  = st.bank;
    assign blk_done = wr_en && (st.idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (wr_en) begin
            if (first) st.mode <= wr_mode;
            if (st.idx == LAST_IDX) begin
                st.idx  <= '0;
                st.bank <= ~st.bank;
            end else begin
                st.idx <= st.idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/isc_rd_ctrl.sv
module isc_rd_ctrl #(
    parameter int N  = 64,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bank_full,
    input  logic          out_ready,
    output logic          out_valid,
    output logic          out_last,
    output logic [AW-1:0] rd_idx,
    output logic          rd_bank,
    output logic          blk_free
);
    localparam logic [AW-1:0] LAST_IDX = AW'(N - 1);

    logic fire;

    assign out_valid = bank_full;
    assign fire      = out_valid && out_ready;
    assign out_last  = out_valid && (rd_idx == LAST_IDX);
    assign blk_free  = fire && (rd_idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_idx  <= '0;
            rd_bank <= 1'b0;
        end else if (fire) begin
            if (rd_idx == LAST_IDX) begin
                rd_idx  <= '0;
                rd_bank <= ~rd_bank;
            end else begin
                rd_idx <= rd_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/coef_iscan.sv
module coef_iscan
    import isc_pkg::*;
#(
    parameter int DIM = 8,
    parameter int W   = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    input  logic         in_alt,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data,
    output logic         out_last
);
    localparam int N     = DIM * DIM;
    localparam int AW    = $clog2(N);
    localparam int NBANK = 2;

    logic [NBANK-1:0] full;
    logic             wr_en, wr_bank, blk_done;
    logic [AW-1:0]    wr_idx, wr_addr;
    scan_mode_e       wr_mode;
    logic             rd_bank, blk_free;
    logic [AW-1:0]    rd_idx;
    logic [W-1:0]     rd_data_a [NBANK];

    isc_wr_ctrl #(.N(N), .AW(AW)) u_wr (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_alt   (in_alt),
        .bank_free(~full[wr_bank]),
        .in_ready (in_ready),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_mode  (wr_mode),
        .wr_bank  (wr_bank),
        .blk_done (blk_done)
    );

    isc_addr_map #(.DIM(DIM), .N(N), .AW(AW)) u_map (
        .idx (wr_idx),
        .mode(wr_mode),
        .addr(wr_addr)
    );

    isc_rd_ctrl #(.N(N), .AW(AW)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .bank_full(full[rd_bank]),
        .out_ready(out_ready),
        .out_valid(out_valid),
        .out_last (out_last),
        .rd_idx   (rd_idx),
        .rd_bank  (rd_bank),
        .blk_free (blk_free)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        isc_bank #(.W(W), .DEPTH(N), .AW(AW)) u_bank (
            .clk    (clk),
            .wr_en  (wr_en && (wr_bank == 1'(b))),
            .wr_addr(wr_addr),
            .wr_data(in_data),
            .rd_addr(rd_idx),
            .rd_data(rd_data_a[b])
        );

        always_ff @(posedge clk) begin
            if (rst)                                 full[b] <= 1'b0;
            else if (blk_done && wr_bank == 1'(b))   full[b] <= 1'b1;
            else if (blk_free && rd_bank == 1'(b))   full[b] <= 1'b0;
        end
    end

    assign out_data = rd_data_a[rd_bank];
endmodule

// File: rtl/coef_iscan_checker.sv
module coef_iscan_checker #(
    parameter int DIM = 8,
    parameter int W   = 12
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         in_ready,
    input logic         out_valid,
    input logic         out_ready,
    input logic [W-1:0] out_data,
    input logic         out_last
);
    localparam int N  = DIM * DIM;
    localparam int AW = $clog2(N);
    localparam logic [AW-1:0] LAST_IDX = AW'(N - 1);

    logic [AW-1:0] ci, co;
    logic [1:0]    occ;
    logic          in_done, out_done;

    assign in_done  = in_valid && in_ready && (ci == LAST_IDX);
    assign out_done = out_valid && out_ready && (co == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            ci  <= '0;
            co  <= '0;
            occ <= '0;
        end else begin
            if (in_valid && in_ready)   ci <= (ci == LAST_IDX) ? '0 : ci + 1'b1;
            if (out_valid && out_ready) co <= (co == LAST_IDX) ? '0 : co + 1'b1;
            occ <= occ + {1'b0, in_done} - {1'b0, out_done};
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R7
    AST_LAST_ONLY_END: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_last |-> co == LAST_IDX); // R4
    AST_LAST_AT_END: assert property (@(posedge clk) disable iff (rst)
        out_valid && co == LAST_IDX |-> out_last); // R4
    AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (rst)
        occ != 2'd3); // R6
    AST_READY_FULL: assert property (@(posedge clk) disable iff (rst)
        in_ready == (occ != 2'd2)); // R6
    AST_VALID_OCC: assert property (@(posedge clk) disable iff (rst)
        out_valid == (occ != 2'd0)); // R8
    AST_FREE_AFTER: assert property (@(posedge clk) disable iff (rst)
        out_done && !in_done |=> in_ready); // R8
endmodule

bind coef_iscan coef_iscan_checker #(.DIM(DIM), .W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .out_last (out_last)
);

// File: tb/tb_coef_iscan.sv
`timescale 1ns/1ps
module tb_coef_iscan;
    localparam int DIM  = 8;
    localparam int N    = DIM * DIM;
    localparam int W    = 12;
    localparam int NBLK = 40;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid, in_ready, in_alt;
    logic [W-1:0] in_data;
    logic         out_valid, out_ready, out_last;
    logic [W-1:0] out_data;

    always #2.5 clk = ~clk;

    coef_iscan #(.DIM(DIM), .W(W)) dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_alt(in_alt),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
    );

    int checks = 0;
    int errors = 0;
    int zz_tab [N];
    int exp_q[$];
    int mode_q[$];
    int cur_blk [N];
    int occ = 0, in_n = 0, out_n = 0, cur_mode = 0;
    int blocks_sent = 0, blocks_out = 0, cyc = 0, seed_dummy;
    logic         prev_stall = 1'b0;
    logic [W-1:0] prev_data;
    logic         prev_last;

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Zigzag by stepping through the grid, independent of any diagonal formula.
    task automatic build_zigzag();
        int v = 0;
        int u = 0;
        for (int n = 0; n < N; n++) begin
            zz_tab[n] = v * DIM + u;
            if ((v + u) % 2 == 0) begin
                if (u == DIM - 1) v++;
                else if (v == 0) u++;
                else begin u++; v--; end
            end else begin
                if (v == DIM - 1) u++;
                else if (u == 0) v++;
                else begin v++; u--; end
            end
        end
    endtask

    function automatic int place(int n, int mode);
        int p = zz_tab[n];
        return mode ? ((p % DIM) * DIM + p / DIM) : p;
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d blocks out", blocks_out, NBLK);
        summary();
        $finish;
    end

    initial begin
        seed_dummy = $urandom(32'h5eed);
        build_zigzag();
        // Directed table points named in the requirements
        check(zz_tab[1] == 1, "R2 zigzag n=1", zz_tab[1], 1);
        check(zz_tab[2] == 8, "R2 zigzag n=2", zz_tab[2], 8);
        check(place(1, 1) == 8, "R3 column n=1", place(1, 1), 8);
        rst = 1'b1; in_valid = 1'b0; in_data = '0; in_alt = 1'b0; out_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(out_last == 1'b0, "R1 out_last", int'(out_last), 0);
        check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);

        while (blocks_out < NBLK) begin
            @(negedge clk);
            check(in_ready == (occ < 2), "R6 in_ready vs held blocks", int'(in_ready), int'(occ < 2));
            check(out_valid == (occ > 0), "R8 out_valid vs held blocks", int'(out_valid), int'(occ > 0));
            if (prev_stall) begin
                check(out_valid == 1'b1, "R7 valid held", int'(out_valid), 1);
                check(out_data == prev_data, "R7 data held", int'(out_data), int'(prev_data));
                check(out_last == prev_last, "R7 last held", int'(out_last), int'(prev_last));
            end

            in_valid = (blocks_sent < NBLK) && ($urandom % 10 < 8);
            in_data  = W'($urandom);
            if (in_n == 0) begin
                if (blocks_sent == 0)      in_alt = 1'b1;
                else if (blocks_sent == 1) in_alt = 1'b0;
                else                       in_alt = 1'($urandom);
            end else begin
                in_alt = 1'($urandom);   // must be ignored (R5)
            end
            out_ready = (cyc < 300) ? 1'b0 : ($urandom % 10 < 7);
            #1;

            if (in_valid && in_ready) begin
                if (in_n == 0) cur_mode = int'(in_alt);
                cur_blk[place(in_n, cur_mode)] = int'(in_data);
                in_n++;
                if (in_n == N) begin
                    for (int k = 0; k < N; k++) begin
                        exp_q.push_back(cur_blk[k]);
                        mode_q.push_back(cur_mode);
                    end
                    in_n = 0;
                    occ++;
                    blocks_sent++;
                end
            end

            if (out_valid && out_ready) begin
                int e;
                int m;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 output without block", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    m = mode_q.pop_front();
                    if (blocks_out == 0)
                        check(int'(out_data) == e, "R5 mode held from first coefficient", int'(out_data), e);
                    else if (m == 1)
                        check(int'(out_data) == e, "R3 column placement", int'(out_data), e);
                    else
                        check(int'(out_data) == e, "R2 zigzag placement", int'(out_data), e);
                end
                check(out_last == (out_n == N - 1), "R4 last flag", int'(out_last), int'(out_n == N - 1));
                out_n++;
                if (out_n == N) begin
                    out_n = 0;
                    occ--;
                    blocks_out++;
                end
            end

            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            prev_last  = out_last;
            cyc++;
        end
        check(exp_q.size() == 0, "R4 word count", exp_q.size(), 0);
        summary();
        $finish;
    end
endmodule